// File: doc/BRIEF.md
# Write Fault Monitor

This block watches the error and consistency conditions that matter while a disk drive writes. It gathers them into two sticky 8-bit status bytes and drives a single summary fault line back to the controller. The first byte holds transfer errors: data parity, transfer timing, write-protect violation, state violation and command parity. These are reported but do not stop the drive. The second byte holds hardware failures: a bad head selection, loss of write current, and write current that disagrees with the write command in either direction.

Any hardware failure sets a pack-unsafe latch. This latch lights the check indicator and asserts a write-terminate output. Software can clear the status bytes with a clear input, but only reset clears the pack-unsafe latch. The command/current cross-check ignores short disagreements that happen while the current switches. A mismatch is flagged only when it lasts for a parameterised number of consecutive clocks, two by default.

Every input is sampled on the rising clock edge. The status registers and the latch change on that same edge, so a condition shows at the outputs one register stage after it is presented.

Top module: `wr_fault_mon`

## Requirements
- R1: Status byte 1 (`stat1_o`) sets bit 0 on data parity error, bit 1 on transfer timing error, bit 2 on protect violation, bit 4 on state violation and bit 7 on command parity error. Bits 3, 5 and 6 always read 0.
- R2: Status byte 2 (`stat2_o`) sets bit 4 on bad head selection, bit 5 on write current loss, bit 6 on write current without write command and bit 7 on write command without write current. Bits 0 to 3 always read 0.
- R3: Status bits are sticky. A high `clr_i` sampled at an edge clears both bytes. A condition sampled at the same edge as the clear still sets its bit.
- R4: Status-byte-1 conditions never set the pack-unsafe latch.
- R5: Any status-byte-2 condition sets pack-unsafe in the same cycle as its status bit. `check_o` and `wr_term_o` are high while the latch is set. `clr_i` does not clear the latch; only reset does.
- R6: `fault_o` is high whenever any status bit is set or pack-unsafe is latched.
- R7: Head selection is flagged when `wr_cmd_i` is high and `head_sel_i` does not have exactly one bit set. The select vector is ignored while `wr_cmd_i` is low.
- R8: A command/current mismatch is flagged only after it has been sampled on MM_CYC consecutive edges (2 by default). A shorter mismatch, or one broken by a matching cycle, sets nothing.
- R9: After reset, both status bytes, `fault_o`, `check_o` and `wr_term_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear both status bytes |
| dpar_err_i | input | 1 | Data parity error |
| xfer_tmg_err_i | input | 1 | Transfer timing error |
| protect_viol_i | input | 1 | Write to protected area |
| state_viol_i | input | 1 | Command not allowed in current state |
| cmd_par_err_i | input | 1 | Command parity error |
| head_sel_i | input | NHEAD | One-hot head select |
| wr_cmd_i | input | 1 | Write command active |
| wr_cur_i | input | 1 | Write current sensed |
| cur_lost_i | input | 1 | Write current loss detected by sensing |
| stat1_o | output | 8 | Transfer error status byte |
| stat2_o | output | 8 | Hardware failure status byte |
| fault_o | output | 1 | Summary fault to controller |
| check_o | output | 1 | Check indicator |
| wr_term_o | output | 1 | Stop writing |

## Verification
The bench drives a one-cycle mismatch, a mismatch broken by a matching cycle, and then a true two-cycle mismatch. A filter that is missing would flag too early, and one whose counter never restarts would flag on the broken run. It clears in the same cycle as a new error, so a design where the clear wins would lose that error. It also clears after a hardware failure, so a design whose clear also drops pack-unsafe would let writing resume. Zero-hot and two-hot head selects are applied both with and without a write command, so a design that ignored the qualifier or the zero-hot case would report the wrong byte.

// File: rtl/wr_fault_mon.sv
module wr_fault_mon #(
  parameter int NHEAD  = 4,
  parameter int MM_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             dpar_err_i,
  input  logic             xfer_tmg_err_i,
  input  logic             protect_viol_i,
  input  logic             state_viol_i,
  input  logic             cmd_par_err_i,
  input  logic [NHEAD-1:0] head_sel_i,
  input  logic             wr_cmd_i,
  input  logic             wr_cur_i,
  input  logic             cur_lost_i,
  output logic [7:0]       stat1_o,
  output logic [7:0]       stat2_o,
  output logic             fault_o,
  output logic             check_o,
  output logic             wr_term_o
);

  localparam int CW = $clog2(MM_CYC + 1);
  localparam logic [CW-1:0] MM_LAST = CW'(MM_CYC - 1);

  logic [7:0]    stat1_q, stat2_q;
  logic          unsafe_q;
  logic [CW-1:0] nocur_cnt, nocmd_cnt;

  wire nocur    = wr_cmd_i & ~wr_cur_i;
  wire nocmd    = wr_cur_i & ~wr_cmd_i;
  wire head_bad = wr_cmd_i && ($countones(head_sel_i) != 1);

  wire [7:0] s1_set = {cmd_par_err_i, 2'b00, state_viol_i, 1'b0,
                       protect_viol_i, xfer_tmg_err_i, dpar_err_i};
  wire [7:0] s2_set = {nocur && (nocur_cnt == MM_LAST),
                       nocmd && (nocmd_cnt == MM_LAST),
                       cur_lost_i, head_bad, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nocur_cnt <= '0;
      nocmd_cnt <= '0;
    end else begin
      if (!nocur) nocur_cnt <= '0;
      else if (nocur_cnt != MM_LAST) nocur_cnt <= nocur_cnt + 1'b1;
      if (!nocmd) nocmd_cnt <= '0;
      else if (nocmd_cnt != MM_LAST) nocmd_cnt <= nocmd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat1_q  <= '0;
      stat2_q  <= '0;
      unsafe_q <= 1'b0;
    end else begin
      stat1_q  <= (clr_i ? 8'h00 : stat1_q) | s1_set;
      stat2_q  <= (clr_i ? 8'h00 : stat2_q) | s2_set;
      unsafe_q <= unsafe_q | (|s2_set);
    end
  end

  assign stat1_o   = stat1_q;
  assign stat2_o   = stat2_q;
  assign fault_o   = (|stat1_q) | (|stat2_q) | unsafe_q;
  assign check_o   = unsafe_q;
  assign wr_term_o = unsafe_q;

  AST_S1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((~stat1_q & $past(stat1_q)) == 8'h00)); // R3
  AST_S2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((~stat2_q & $past(stat2_q)) == 8'h00)); // R3
  AST_UNSAFE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsafe_q) |-> (|stat2_q)); // R4
  AST_S2_UNSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|stat2_q) |-> unsafe_q); // R5
  AST_UNSAFE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe_q |=> unsafe_q); // R5
  AST_HEAD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat2_q[4]) |-> $past(wr_cmd_i)); // R7
  AST_NOCUR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat2_q[7]) |-> $past(nocur) && $past(nocur, 2)); // R8
  AST_NOCMD_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat2_q[6]) |-> $past(nocmd) && $past(nocmd, 2)); // R8

endmodule

// File: tb/tb_wr_fault_mon.sv
module tb_wr_fault_mon;
  localparam int NH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic dpar, xfer, prot, stv, cpar;
  logic [NH-1:0] head = '0;
  logic cmd = 1'b0, cur = 1'b0, lost = 1'b0;
  logic [7:0] stat1, stat2;
  logic fault, check, term;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] e1;
    logic [7:0] e2;
    logic       eu;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  wr_fault_mon #(.NHEAD(NH), .MM_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .dpar_err_i(dpar), .xfer_tmg_err_i(xfer), .protect_viol_i(prot),
    .state_viol_i(stv), .cmd_par_err_i(cpar), .head_sel_i(head),
    .wr_cmd_i(cmd), .wr_cur_i(cur), .cur_lost_i(lost),
    .stat1_o(stat1), .stat2_o(stat2), .fault_o(fault),
    .check_o(check), .wr_term_o(term));

  task automatic compare(input logic [7:0] e1, input logic [7:0] e2,
                         input logic eu, input string tag);
    logic ef;
    ef = (|e1) | (|e2) | eu;
    checks++;
    if (stat1 !== e1 || stat2 !== e2 || check !== eu || term !== eu || fault !== ef) begin
      errors++;
      $display("FAIL %s: got s1=%h s2=%h chk=%b term=%b flt=%b exp s1=%h s2=%h chk=%b term=%b flt=%b",
               tag, stat1, stat2, check, term, fault, e1, e2, eu, eu, ef);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        compare(it.e1, it.e2, it.eu, it.tag);
      end
    end
  end

  // s1 bits: 0 dpar, 1 xfer, 2 prot, 3 state, 4 cmd parity
  task automatic step(input logic [4:0] s1, input logic [NH-1:0] hd,
                      input logic c, input logic w, input logic l, input logic cl,
                      input logic [7:0] e1, input logic [7:0] e2,
                      input logic eu, input string tag);
    exp_t it;
    @(negedge clk);
    {cpar, stv, prot, xfer, dpar} = s1;
    head = hd; cmd = c; cur = w; lost = l; clr_i = cl;
    it.e1 = e1; it.e2 = e2; it.eu = eu; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    {cpar, stv, prot, xfer, dpar} = '0;
    head = '0; cmd = 0; cur = 0; lost = 0; clr_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare(8'h00, 8'h00, 1'b0, "R9 reset state");
  endtask

  initial begin
    repeat (500) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    {cpar, stv, prot, xfer, dpar} = '0;
    do_reset();
    step(5'b00000, 4'b0000, 0, 0, 0, 0, 8'h00, 8'h00, 0, "R7 idle no head check");
    step(5'b00001, 4'b0000, 0, 0, 0, 0, 8'h01, 8'h00, 0, "R1 data parity bit0");
    step(5'b00110, 4'b0000, 0, 0, 0, 0, 8'h07, 8'h00, 0, "R1 timing/protect bits1,2");
    step(5'b11000, 4'b0000, 0, 0, 0, 0, 8'h97, 8'h00, 0, "R4 R6 state/cmdpar, no unsafe");
    step(5'b00000, 4'b0000, 0, 0, 0, 1, 8'h00, 8'h00, 0, "R3 clear");
    step(5'b00001, 4'b0000, 0, 0, 0, 1, 8'h01, 8'h00, 0, "R3 set wins over clear");
    step(5'b00000, 4'b0000, 0, 0, 0, 0, 8'h01, 8'h00, 0, "R3 sticky");
    step(5'b00000, 4'b0000, 0, 0, 0, 1, 8'h00, 8'h00, 0, "R3 clear again");
    step(5'b00000, 4'b0001, 1, 1, 0, 0, 8'h00, 8'h00, 0, "R2 normal write");
    step(5'b00000, 4'b0001, 1, 0, 0, 0, 8'h00, 8'h00, 0, "R8 one-cycle no current");
    step(5'b00000, 4'b0001, 1, 1, 0, 0, 8'h00, 8'h00, 0, "R8 match breaks run");
    step(5'b00000, 4'b0001, 1, 0, 0, 0, 8'h00, 8'h00, 0, "R8 first of run");
    step(5'b00000, 4'b0001, 1, 0, 0, 0, 8'h00, 8'h80, 1, "R8 R5 cmd without current bit7");
    step(5'b00000, 4'b0001, 0, 0, 0, 1, 8'h00, 8'h00, 1, "R5 R6 clear keeps unsafe");
    step(5'b00000, 4'b0000, 0, 0, 0, 0, 8'h00, 8'h00, 1, "R5 unsafe held");
    do_reset();
    step(5'b00000, 4'b0001, 0, 1, 0, 0, 8'h00, 8'h00, 0, "R8 current without cmd first");
    step(5'b00000, 4'b0001, 0, 1, 0, 0, 8'h00, 8'h40, 1, "R2 R8 current without cmd bit6");
    do_reset();
    step(5'b00000, 4'b0110, 0, 0, 0, 0, 8'h00, 8'h00, 0, "R7 two-hot ignored when idle");
    step(5'b00000, 4'b0000, 1, 1, 0, 0, 8'h00, 8'h10, 1, "R7 R2 zero-hot while writing bit4");
    do_reset();
    step(5'b00000, 4'b0110, 1, 1, 0, 0, 8'h00, 8'h10, 1, "R7 two-hot while writing");
    do_reset();
    step(5'b00000, 4'b0100, 1, 1, 1, 0, 8'h00, 8'h20, 1, "R2 R5 current loss bit5");
    step(5'b00000, 4'b0100, 1, 1, 0, 0, 8'h00, 8'h20, 1, "R5 loss sticky");
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule